// File: doc/BRIEF.md
# I2C Byte Buffer Pair with Threshold Events

This block sits between a processor-side data port and an I2C byte engine. It holds one first-in first-out byte store per direction: the processor writes bytes that the engine later pulls onto the bus, and the engine pushes received bytes that the processor later reads. Both stores have the same depth, which is fixed at build time and reported as a two-bit code.

A 16-bit configuration word sets a fill threshold for each direction, turns on a DMA request line for each direction, and carries a one-shot clear bit for each store. From these the block derives a ready level per direction. It also derives a drain level for the tail of a transfer, where fewer bytes remain than the threshold and the normal ready level will not come. A 16-bit status word gives the depth code and the fill count of the direction in use, so software knows how many bytes to move on a drain event.

Top module: `i2c_fifo_buf`

## Requirements
- R1: After reset both stores are empty, the configuration reads back as zero (both thresholds equal one, DMA off), both error flags are low and no ready, drain or request level is raised except transmit ready.
- R2: Bytes leave each store in the order they entered: the transmit store from cpu_wdata to eng_tx_data, the receive store from eng_rx_data to cpu_rdata. The head byte is visible on the output while the store is not empty.
- R3: buf_stat bits 15:14 hold the depth code s, and each store holds exactly 8 << s bytes.
- R4: buf_stat low bits (width enough for the full depth) hold the transmit fill count when dir_tx is 1 and the receive fill count when dir_tx is 0; all other status bits are zero.
- R5: A configuration write loads the receive threshold field from bits 13:8 and the transmit threshold field from bits 5:0, each meaning threshold minus one and masked to depth minus one; bit 15 enables receive DMA and bit 7 enables transmit DMA. cfg_rdata returns these fields at the same positions.
- R6: A configuration write with bit 14 set empties the receive store and clears rx_udf; with bit 6 set it empties the transmit store and clears tx_ovf. Both clear bits read back as zero, and a clear wins over any push, pop or error in the same cycle.
- R7: rx_ready is high when the receive fill is at least the receive threshold; tx_ready is high when the free transmit space is at least the transmit threshold.
- R8: With xfer_left the bytes the processor still has to move, tx_drain is high when dir_tx is 1, xfer_left is nonzero, below the transmit threshold and no more than the free transmit space; rx_drain is high when dir_tx is 0, xfer_left is nonzero, below the receive threshold and no more than the receive fill.
- R9: A processor write into a full transmit store is dropped and sets the sticky tx_ovf flag; a processor read of an empty receive store changes nothing and sets the sticky rx_udf flag.
- R10: rx_dma_req equals receive DMA enable and rx_ready; tx_dma_req equals transmit DMA enable and tx_ready.
- R11: An engine push into a full receive store or an engine pop from an empty transmit store is dropped without changing either store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_rdata | output | 16 | Configuration readback |
| buf_stat | output | 16 | Depth code and active fill count |
| dir_tx | input | 1 | Active direction, 1 for transmit |
| xfer_left | input | 16 | Bytes the processor still has to move |
| cpu_wr | input | 1 | Processor write into transmit store |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_rd | input | 1 | Processor read from receive store |
| cpu_rdata | output | 8 | Receive store head byte |
| eng_tx_pop | input | 1 | Engine takes transmit head byte |
| eng_tx_data | output | 8 | Transmit store head byte |
| eng_tx_valid | output | 1 | Transmit store not empty |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_room | output | 1 | Receive store not full |
| tx_ready | output | 1 | Transmit threshold level |
| rx_ready | output | 1 | Receive threshold level |
| tx_drain | output | 1 | Transmit tail level |
| rx_drain | output | 1 | Receive tail level |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_ovf | output | 1 | Sticky transmit overflow flag |
| rx_udf | output | 1 | Sticky receive underflow flag |

## Verification
The embedded properties assume nothing of the push and pop strobes: a strobe into a full or out of an empty store must simply be dropped, so the stimulus drives both sides freely, including deliberate pushes past full and pops past empty in long fill-biased and drain-biased phases. The sticky flag properties assume the only way to lower a flag is reset or the matching clear bit, which the stimulus exercises only through configuration writes. xfer_left and dir_tx are taken as arbitrary levels that may change any cycle, and the stimulus redraws them often so the tail conditions are hit on both sides of each threshold.

// File: rtl/i2c_fifo_pkg.sv
package i2c_fifo_pkg;

    // configuration word layout; these positions are decoded by software
    localparam int FLD_W      = 6;
    localparam int TX_THR_LSB = 0;
    localparam int TX_CLR_BIT = 6;
    localparam int TX_DMA_BIT = 7;
    localparam int RX_THR_LSB = 8;
    localparam int RX_CLR_BIT = 14;
    localparam int RX_DMA_BIT = 15;
    localparam int CODE_LSB   = 14;

    typedef struct packed {
        logic             rx_dma;
        logic [FLD_W-1:0] rx_thr;
        logic             tx_dma;
        logic [FLD_W-1:0] tx_thr;
    } buf_cfg_t;

    function automatic int depth_of(input int code);
        return 8 << code;
    endfunction

    function automatic logic [15:0] pack_cfg(input buf_cfg_t c);
        logic [15:0] w;
        w = '0;
        w[RX_DMA_BIT]                = c.rx_dma;
        w[RX_THR_LSB +: FLD_W]       = c.rx_thr;
        w[TX_DMA_BIT]                = c.tx_dma;
        w[TX_THR_LSB +: FLD_W]       = c.tx_thr;
        return w;
    endfunction

endpackage

// File: rtl/i2c_fifo_cfg.sv
module i2c_fifo_cfg
    import i2c_fifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [15:0] wdata,
    output buf_cfg_t    cfg,
    output logic        rx_clr,
    output logic        tx_clr,
    output logic [15:0] rdata
);
    localparam logic [FLD_W-1:0] FMASK = FLD_W'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr) begin
            cfg.rx_dma <= wdata[RX_DMA_BIT];
            cfg.rx_thr <= wdata[RX_THR_LSB +: FLD_W] & FMASK;
            cfg.tx_dma <= wdata[TX_DMA_BIT];
            cfg.tx_thr <= wdata[TX_THR_LSB +: FLD_W] & FMASK;
        end
    end

    // clear bits act only in the write cycle and are never stored
    assign rx_clr = wr & wdata[RX_CLR_BIT];
    assign tx_clr = wr & wdata[TX_CLR_BIT];
    assign rdata  = pack_cfg(cfg);

    // R5: a write is visible on the readback one cycle later
    a_r5_cfg_load: assert property (@(posedge clk) disable iff (rst)
        wr |=> rdata[RX_THR_LSB +: FLD_W] == ($past(wdata[RX_THR_LSB +: FLD_W]) & FMASK)
            && rdata[TX_DMA_BIT] == $past(wdata[TX_DMA_BIT]));

    // R6: clear bits never read back as set
    a_r6_clr_selfclear: assert property (@(posedge clk) disable iff (rst)
        wr |=> !rdata[RX_CLR_BIT] && !rdata[TX_CLR_BIT]);

endmodule

// File: rtl/i2c_byte_fifo.sv
module i2c_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          push_ok, pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push & ~full;
    assign pop_ok  = pop & ~empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (push_ok && !clr) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push_ok) wp <= wp + AW'(1);
            if (pop_ok)  rp <= rp + AW'(1);
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    // R3: the fill never exceeds the built depth
    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R6: a clear leaves the store empty
    a_r6_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr |=> empty);

    // R9 / R11: a push into a full store is dropped
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
        full && push && !pop && !clr |=> full && $stable(wp));

    // R11: a pop from an empty store is dropped
    a_r11_no_underflow: assert property (@(posedge clk) disable iff (rst)
        empty && pop && !push && !clr |=> empty && $stable(rp));

endmodule

// File: rtl/i2c_fifo_buf.sv
module i2c_fifo_buf
    import i2c_fifo_pkg::*;
#(
    parameter int DEPTH_CODE = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [15:0] cfg_wdata,
    output logic [15:0] cfg_rdata,
    output logic [15:0] buf_stat,
    input  logic        dir_tx,
    input  logic [15:0] xfer_left,
    input  logic        cpu_wr,
    input  logic [7:0]  cpu_wdata,
    input  logic        cpu_rd,
    output logic [7:0]  cpu_rdata,
    input  logic        eng_tx_pop,
    output logic [7:0]  eng_tx_data,
    output logic        eng_tx_valid,
    input  logic        eng_rx_push,
    input  logic [7:0]  eng_rx_data,
    output logic        eng_rx_room,
    output logic        tx_ready,
    output logic        rx_ready,
    output logic        tx_drain,
    output logic        rx_drain,
    output logic        tx_dma_req,
    output logic        rx_dma_req,
    output logic        tx_ovf,
    output logic        rx_udf
);
    localparam int DEPTH = depth_of(DEPTH_CODE);
    localparam int CW    = $clog2(DEPTH + 1);

    buf_cfg_t      cfg;
    logic          rx_clr, tx_clr;
    logic [CW-1:0] tx_count, rx_count, tx_free, tx_thr, rx_thr;
    logic          tx_full, tx_empty, rx_full, rx_empty;

    i2c_fifo_cfg #(.DEPTH(DEPTH)) u_cfg (
        .clk(clk), .rst(rst), .wr(cfg_wr), .wdata(cfg_wdata),
        .cfg(cfg), .rx_clr(rx_clr), .tx_clr(tx_clr), .rdata(cfg_rdata)
    );

    i2c_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
        .clk(clk), .rst(rst), .clr(tx_clr),
        .push(cpu_wr), .din(cpu_wdata), .pop(eng_tx_pop), .dout(eng_tx_data),
        .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    i2c_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
        .clk(clk), .rst(rst), .clr(rx_clr),
        .push(eng_rx_push), .din(eng_rx_data), .pop(cpu_rd), .dout(cpu_rdata),
        .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    assign eng_tx_valid = ~tx_empty;
    assign eng_rx_room  = ~rx_full;

    // thresholds are stored minus one
    assign tx_thr  = CW'(cfg.tx_thr) + CW'(1);
    assign rx_thr  = CW'(cfg.rx_thr) + CW'(1);
    assign tx_free = CW'(DEPTH) - tx_count;

    assign tx_ready   = (tx_free >= tx_thr);
    assign rx_ready   = (rx_count >= rx_thr);
    assign tx_dma_req = cfg.tx_dma & tx_ready;
    assign rx_dma_req = cfg.rx_dma & rx_ready;

    assign tx_drain = dir_tx && (xfer_left != '0) && (xfer_left < 16'(tx_thr))
                      && (16'(tx_free) >= xfer_left);
    assign rx_drain = !dir_tx && (xfer_left != '0) && (xfer_left < 16'(rx_thr))
                      && (16'(rx_count) >= xfer_left);

    always_comb begin
        buf_stat = '0;
        buf_stat[CODE_LSB +: 2] = 2'(DEPTH_CODE);
        buf_stat[CW-1:0]        = dir_tx ? tx_count : rx_count;
    end

    always_ff @(posedge clk) begin
        if (rst || tx_clr)          tx_ovf <= 1'b0;
        else if (cpu_wr && tx_full) tx_ovf <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || rx_clr)           rx_udf <= 1'b0;
        else if (cpu_rd && rx_empty) rx_udf <= 1'b1;
    end

    // R9: error flags hold until their clear
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        tx_ovf && !tx_clr |=> tx_ovf);
    a_r9_udf_sticky: assert property (@(posedge clk) disable iff (rst)
        rx_udf && !rx_clr |=> rx_udf);

    // R6: a clear drops the flag of its direction
    a_r6_clear_flag: assert property (@(posedge clk) disable iff (rst)
        tx_clr |=> !tx_ovf && tx_ready);

    // R7: transmit ready implies room for at least one byte
    a_r7_ready_room: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> !tx_full);

    // R7: receive ready implies data present
    a_r7_ready_data: assert property (@(posedge clk) disable iff (rst)
        rx_ready |-> !rx_empty);

endmodule

// File: tb/tb_i2c_fifo_buf.sv
module tb_i2c_fifo_buf;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [15:0] cfg_wdata, cfg_rdata, buf_stat, xfer_left;
    logic        dir_tx, cpu_wr, cpu_rd, eng_tx_pop, eng_rx_push;
    logic [7:0]  cpu_wdata, cpu_rdata, eng_tx_data, eng_rx_data;
    logic        eng_tx_valid, eng_rx_room, tx_ready, rx_ready, tx_drain, rx_drain;
    logic        tx_dma_req, rx_dma_req, tx_ovf, rx_udf;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    int  rx_f = 0, tx_f = 0;
    bit  rx_dma_m = 0, tx_dma_m = 0, tx_ovf_m = 0, rx_udf_m = 0;

    always #4 clk = ~clk;

    i2c_fifo_buf #(.DEPTH_CODE(1)) dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .buf_stat(buf_stat), .dir_tx(dir_tx),
        .xfer_left(xfer_left), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .eng_tx_pop(eng_tx_pop),
        .eng_tx_data(eng_tx_data), .eng_tx_valid(eng_tx_valid),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .eng_rx_room(eng_rx_room), .tx_ready(tx_ready), .rx_ready(rx_ready),
        .tx_drain(tx_drain), .rx_drain(rx_drain), .tx_dma_req(tx_dma_req),
        .rx_dma_req(rx_dma_req), .tx_ovf(tx_ovf), .rx_udf(rx_udf)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit e_tx_ready();
        return (DEPTH - txq.size()) >= tx_f + 1;
    endfunction
    function automatic bit e_rx_ready();
        return rxq.size() >= rx_f + 1;
    endfunction
    function automatic bit e_tx_drain();
        int l = int'(xfer_left);
        return dir_tx && l != 0 && l < tx_f + 1 && (DEPTH - txq.size()) >= l;
    endfunction
    function automatic bit e_rx_drain();
        int l = int'(xfer_left);
        return !dir_tx && l != 0 && l < rx_f + 1 && rxq.size() >= l;
    endfunction
    function automatic int e_cfg();
        return (int'(rx_dma_m) << 15) | (rx_f << 8) | (int'(tx_dma_m) << 7) | tx_f;
    endfunction

    // reference update using the inputs held across the edge
    task automatic model_edge();
        int tsz = txq.size();
        int rsz = rxq.size();
        bit tclr = cfg_wr && cfg_wdata[6];
        bit rclr = cfg_wr && cfg_wdata[14];
        if (rst) begin
            txq.delete(); rxq.delete();
            rx_f = 0; tx_f = 0; rx_dma_m = 0; tx_dma_m = 0; tx_ovf_m = 0; rx_udf_m = 0;
            return;
        end
        if (tclr) begin
            txq.delete(); tx_ovf_m = 0;
        end else begin
            if (eng_tx_pop && tsz > 0) void'(txq.pop_front());
            if (cpu_wr && tsz < DEPTH) txq.push_back(cpu_wdata);
            if (cpu_wr && tsz == DEPTH) tx_ovf_m = 1;
        end
        if (rclr) begin
            rxq.delete(); rx_udf_m = 0;
        end else begin
            if (cpu_rd && rsz > 0) void'(rxq.pop_front());
            if (eng_rx_push && rsz < DEPTH) rxq.push_back(eng_rx_data);
            if (cpu_rd && rsz == 0) rx_udf_m = 1;
        end
        if (cfg_wr) begin
            rx_dma_m = cfg_wdata[15];
            tx_dma_m = cfg_wdata[7];
            rx_f = int'(cfg_wdata[13:8]) & (DEPTH - 1);
            tx_f = int'(cfg_wdata[5:0]) & (DEPTH - 1);
        end
    endtask

    task automatic check_all();
        chk("R3", "depth code", int'(buf_stat[15:14]), 1);
        chk("R4", "status fill", int'(buf_stat[13:0]), dir_tx ? txq.size() : rxq.size());
        chk("R2", "tx valid", int'(eng_tx_valid), int'(txq.size() > 0));
        if (txq.size() > 0) chk("R2", "tx head", int'(eng_tx_data), int'(txq[0]));
        chk("R2", "rx room", int'(eng_rx_room), int'(rxq.size() < DEPTH));
        if (rxq.size() > 0) chk("R2", "rx head", int'(cpu_rdata), int'(rxq[0]));
        chk("R7", "tx ready", int'(tx_ready), int'(e_tx_ready()));
        chk("R7", "rx ready", int'(rx_ready), int'(e_rx_ready()));
        chk("R8", "tx drain", int'(tx_drain), int'(e_tx_drain()));
        chk("R8", "rx drain", int'(rx_drain), int'(e_rx_drain()));
        chk("R10", "tx dma", int'(tx_dma_req), int'(tx_dma_m && e_tx_ready()));
        chk("R10", "rx dma", int'(rx_dma_req), int'(rx_dma_m && e_rx_ready()));
        chk("R9", "tx ovf", int'(tx_ovf), int'(tx_ovf_m));
        chk("R9", "rx udf", int'(rx_udf), int'(rx_udf_m));
        chk("R5", "cfg readback", int'(cfg_rdata), e_cfg());
    endtask

    task automatic idle();
        cfg_wr = 0; cfg_wdata = 0; cpu_wr = 0; cpu_rd = 0;
        eng_tx_pop = 0; eng_rx_push = 0;
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int phase;
        void'($urandom(32'd20240611));
        rst = 1; idle(); dir_tx = 1; xfer_left = 0; cpu_wdata = 0; eng_rx_data = 0;
        repeat (3) cycle();
        rst = 0;
        cycle();
        // R1: reset state
        chk("R1", "cfg zero", int'(cfg_rdata), 0);
        chk("R1", "tx empty", int'(eng_tx_valid), 0);
        chk("R1", "rx ready low", int'(rx_ready), 0);
        chk("R1", "tx ready high", int'(tx_ready), 1);
        chk("R1", "flags", int'({tx_ovf, rx_udf}), 0);

        // R9: fill transmit store past full
        for (int i = 0; i < DEPTH + 2; i++) begin
            cpu_wr = 1; cpu_wdata = 8'(i * 7 + 3);
            cycle();
        end
        idle();
        chk("R9", "count held at depth", int'(buf_stat[4:0]), DEPTH);
        chk("R9", "overflow flagged", int'(tx_ovf), 1);

        // R11: engine push into full receive store, pop from empty transmit store
        dir_tx = 0;
        for (int i = 0; i < DEPTH + 3; i++) begin
            eng_rx_push = 1; eng_rx_data = 8'(200 - i);
            cycle();
        end
        idle();
        chk("R11", "rx count held", int'(buf_stat[4:0]), DEPTH);
        chk("R11", "rx head kept", int'(cpu_rdata), 200);
        chk("R11", "rx flag untouched", int'(rx_udf), 0);

        // R6: clear transmit store only
        cfg_wr = 1; cfg_wdata = 16'h0040 | 16'h0003;
        cycle();
        idle();
        dir_tx = 1;
        #1;
        chk("R6", "tx cleared", int'(buf_stat[4:0]), 0);
        chk("R6", "tx ovf cleared", int'(tx_ovf), 0);
        chk("R6", "clear bit reads zero", int'(cfg_rdata[6]), 0);
        eng_tx_pop = 1;
        cycle();
        idle();
        chk("R11", "pop empty ignored", int'(eng_tx_valid), 0);

        // R9: read empty receive store after clearing it
        cfg_wr = 1; cfg_wdata = 16'h4000;
        cycle();
        idle();
        cpu_rd = 1;
        cycle();
        idle();
        chk("R9", "udf flagged", int'(rx_udf), 1);
        dir_tx = 0; #1;
        chk("R9", "rx still empty", int'(buf_stat[4:0]), 0);

        // constrained random phases
        for (int n = 0; n < 4000; n++) begin
            phase = (n / 150) % 2;
            idle();
            cpu_wr      = ($urandom % 4) < (phase ? 3 : 1);
            eng_tx_pop  = ($urandom % 4) < (phase ? 1 : 3);
            eng_rx_push = ($urandom % 4) < (phase ? 3 : 1);
            cpu_rd      = ($urandom % 4) < (phase ? 1 : 3);
            cpu_wdata   = 8'($urandom);
            eng_rx_data = 8'($urandom);
            if ($urandom % 40 == 0) begin
                cfg_wr = 1;
                cfg_wdata = 16'($urandom);
                if ($urandom % 4 != 0) cfg_wdata = cfg_wdata & 16'hBFBF;
            end
            if ($urandom % 30 == 0) dir_tx = ~dir_tx;
            xfer_left = 16'($urandom % 20);
            cycle();
        end
        idle();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule